// File: doc/BRIEF.md
# Packed Syllable Instruction Sequencer

This block sits between an instruction memory and the execute stage of a small stack machine. It fetches 32-bit words one at a time over a synchronous read port and sorts each by its two top bits. A long-immediate word turns into one push request whose value is the low 31 bits moved up by one place. A packed word is cut into five 6-bit syllables, which are offered one after another. A word from the reserved encoding stops the block and raises a fault pulse.

The execute stage takes each item over a valid/ready handshake. It can send a jump back to the block, which drops what is left of the current word and restarts fetching at the target. A freeze input holds the block completely still. The program counter and a slot counter are brought out so the execute stage can see where the next item comes from.

Top module: `pksyl_sequencer`

## Requirements
- R1: After reset, pc is 0, slot is 0, op_valid and fault are low, and the first read request goes to address 0.
- R2: A word with bit 31 set gives exactly one item with op_is_push = 1. Its op_imm is bits 30..0 moved up one place with 0 in bit 0 (0xC0404040 gives 0x80808080). The slot counter stays 0 while that item is offered.
- R3: A word with bits 31..30 = 00 gives five items with op_is_push = 0. op_syl takes bits 29..24 first, then 23..18, 17..12, 11..6, and bits 5..0 last.
- R4: A word with bits 31..30 = 01 holds fault high for exactly one cycle and leaves pc at that word's address. After that, no read request is made and no item is offered until reset, and jumps have no effect.
- R5: When a word arrives, pc advances by 4. While the k-th syllable (counting from 1) is offered, slot reads k mod 5, so the third syllable of the word at 0x200 shows pc 0x204 and slot 3. slot never leaves 0..4.
- R6: While op_valid is high and op_ready is low, with no jump, the offered item, pc and slot are unchanged in the next cycle.
- R7: While freeze is high, imem_req and op_valid are low, pc and slot hold, and jumps are ignored.
- R8: When jump_valid is high, the block is not frozen and the block is not stopped, the next cycle shows pc = jump_target and slot = 0. The remaining items of the current word are dropped, and the next fetch reads from the target. A jump wins over a handshake in the same cycle.
- R9: imem_req is high only when a new word is needed, with imem_addr = pc. The word is taken from imem_rdata one cycle later. A following word is requested only after the last item of the current word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| freeze | input | 1 | Hold all state, no requests or items |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | AW | Read address (byte address of the word) |
| imem_rdata | input | WORD_W | Read data, valid one cycle after the request |
| op_valid | output | 1 | Item offered to execute stage |
| op_ready | input | 1 | Execute stage accepts the item |
| op_is_push | output | 1 | Item is a long-immediate push |
| op_syl | output | SYL_W | Current syllable |
| op_imm | output | WORD_W | Expanded immediate value |
| jump_valid | input | 1 | Redirect request |
| jump_target | input | AW | Redirect address |
| fault | output | 1 | One-cycle pulse on a reserved-format word |
| pc | output | AW | Address of the next word |
| slot | output | SC_W | Index of the next syllable |

## Verification
A wrong slot counter shows up at once as a syllable taken from the wrong field of op_syl, together with a slot value that breaks the k mod 5 pattern. Either appears within the same cycle as the affected item. A wrong pc or fetch state shows up on the next read request as a bad imem_addr. It can also show up as a request that comes too early, too late, or twice per word. A stale word register shows as wrong items after a jump or a freeze. The model in the bench compares every output on every clock, so each of these cases is reported in the cycle it first reaches a port.

// File: rtl/pksyl_pkg.sv
package pksyl_pkg;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_WAIT  = 2'd1,
      ST_ISSUE = 2'd2,
      ST_STOP  = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      F_PACK = 2'd0,
      F_RSVD = 2'd1,
      F_LIMM = 2'd2
   } word_fmt_e;

   // sort a word by its two top bits
   function automatic word_fmt_e classify(input logic [1:0] top);
      word_fmt_e f;
      if (top[1])      f = F_LIMM;
      else if (top[0]) f = F_RSVD;
      else             f = F_PACK;
      return f;
   endfunction

endpackage

// File: rtl/pksyl_slot.sv
// Slot counter: value shown is the index of the next syllable.
// The syllable on offer is the one before it, modulo NSYL.
module pksyl_slot #(
   parameter  int NSYL = 5,
   localparam int SC_W = $clog2(NSYL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            start,
   input  logic            adv,
   output logic [SC_W-1:0] slot,
   output logic [SC_W-1:0] cur_idx,
   output logic            last
);
   localparam logic [SC_W-1:0] TOP = SC_W'(NSYL - 1);

   logic [SC_W-1:0] sc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q <= '0;
      end else if (clr) begin
         sc_q <= '0;
      end else if (start) begin
         sc_q <= SC_W'(1);
      end else if (adv && !last) begin
         sc_q <= (sc_q == TOP) ? '0 : sc_q + SC_W'(1);
      end
   end

   assign last    = (sc_q == '0);
   assign cur_idx = last ? TOP : sc_q - SC_W'(1);
   assign slot    = sc_q;
endmodule

// File: rtl/pksyl_unpack.sv
// Splits the low part of a word into syllable fields and the expanded immediate.
module pksyl_unpack #(
   parameter  int WORD_W = 32,
   parameter  int SYL_W  = 6,
   parameter  int NSYL   = 5,
   localparam int SC_W   = $clog2(NSYL),
   localparam int LO_W   = WORD_W - 1
) (
   input  logic [LO_W-1:0]   word_lo,
   input  logic [SC_W-1:0]   idx,
   output logic [SYL_W-1:0]  syl,
   output logic [WORD_W-1:0] imm
);
   localparam int FLD_TOP = NSYL * SYL_W - 1;

   logic [SYL_W-1:0] fld [NSYL];

   // field 0 is the most significant syllable and runs first
   for (genvar g = 0; g < NSYL; g++) begin : g_fld
      assign fld[g] = word_lo[FLD_TOP - g*SYL_W -: SYL_W];
   end

   always_comb begin
      syl = '0;
      for (int g = 0; g < NSYL; g++) begin
         if (idx == SC_W'(g)) syl = fld[g];
      end
   end

   assign imm = {word_lo, 1'b0};
endmodule

// File: rtl/pksyl_ctrl.sv
// Fetch/issue control and program counter.
module pksyl_ctrl
   import pksyl_pkg::*;
#(
   parameter int AW     = 32,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze,
   input  logic              jump_valid,
   input  logic [AW-1:0]     jump_target,
   input  logic              op_ready,
   input  logic [WORD_W-1:0] imem_rdata,
   input  logic              slot_last,
   output logic              imem_req,
   output logic              op_valid,
   output logic              fault,
   output logic [AW-1:0]     pc,
   output logic [WORD_W-2:0] word_lo,
   output logic              is_push,
   output logic              slot_clr,
   output logic              slot_start,
   output logic              slot_adv
);
   localparam logic [AW-1:0] STEP = AW'(WORD_W / 8);

   seq_state_e        st_q, st_d;
   logic [AW-1:0]     pc_q, pc_d;
   logic [WORD_W-2:0] word_q;
   logic              push_q, fault_q;
   word_fmt_e         fmt;
   logic              live, redirect, accept, fire, done;

   assign fmt      = classify(imem_rdata[WORD_W-1 -: 2]);
   assign live     = !freeze && (st_q != ST_STOP);
   assign redirect = live && jump_valid;
   assign accept   = live && !jump_valid && (st_q == ST_WAIT);
   assign imem_req = (st_q == ST_FETCH) && !freeze;
   assign op_valid = (st_q == ST_ISSUE) && !freeze;
   assign fire     = op_valid && op_ready && !jump_valid;
   assign done     = fire && (push_q || slot_last);

   always_comb begin
      st_d = st_q;
      pc_d = pc_q;
      if (freeze) begin
         // a read in flight is dropped and repeated later
         if (st_q == ST_WAIT) st_d = ST_FETCH;
      end else if (redirect) begin
         st_d = ST_FETCH;
         pc_d = jump_target;
      end else begin
         unique case (st_q)
            ST_FETCH: st_d = ST_WAIT;
            ST_WAIT: begin
               if (fmt == F_RSVD) begin
                  st_d = ST_STOP;
               end else begin
                  st_d = ST_ISSUE;
                  pc_d = pc_q + STEP;
               end
            end
            ST_ISSUE: if (done) st_d = ST_FETCH;
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_FETCH;
         pc_q    <= '0;
         word_q  <= '0;
         push_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         pc_q    <= pc_d;
         fault_q <= accept && (fmt == F_RSVD);
         if (accept && (fmt != F_RSVD)) begin
            word_q <= imem_rdata[WORD_W-2:0];
            push_q <= (fmt == F_LIMM);
         end
      end
   end

   assign pc         = pc_q;
   assign fault      = fault_q;
   assign word_lo    = word_q;
   assign is_push    = push_q;
   assign slot_clr   = redirect;
   assign slot_start = accept && (fmt == F_PACK);
   assign slot_adv   = fire && !push_q;
endmodule

// File: rtl/pksyl_sequencer.sv
module pksyl_sequencer #(
   parameter  int AW     = 32,
   parameter  int WORD_W = 32,
   parameter  int SYL_W  = 6,
   parameter  int NSYL   = 5,
   localparam int SC_W   = $clog2(NSYL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze,
   output logic              imem_req,
   output logic [AW-1:0]     imem_addr,
   input  logic [WORD_W-1:0] imem_rdata,
   output logic              op_valid,
   input  logic              op_ready,
   output logic              op_is_push,
   output logic [SYL_W-1:0]  op_syl,
   output logic [WORD_W-1:0] op_imm,
   input  logic              jump_valid,
   input  logic [AW-1:0]     jump_target,
   output logic              fault,
   output logic [AW-1:0]     pc,
   output logic [SC_W-1:0]   slot
);
   if (WORD_W != 2 + NSYL * SYL_W) begin : g_bad_layout
      $error("word width must equal two format bits plus all syllables");
   end
   if (NSYL < 2) begin : g_bad_nsyl
      $error("at least two syllables per word are needed");
   end
   if (WORD_W % 8 != 0) begin : g_bad_bytes
      $error("word width must be a whole number of bytes");
   end
   if (AW < 3) begin : g_bad_aw
      $error("address width too small");
   end

   logic [WORD_W-2:0] word_lo;
   logic              slot_clr, slot_start, slot_adv, slot_last;
   logic [SC_W-1:0]   cur_idx;

   pksyl_ctrl #(.AW(AW), .WORD_W(WORD_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze     (freeze),
      .jump_valid (jump_valid),
      .jump_target(jump_target),
      .op_ready   (op_ready),
      .imem_rdata (imem_rdata),
      .slot_last  (slot_last),
      .imem_req   (imem_req),
      .op_valid   (op_valid),
      .fault      (fault),
      .pc         (pc),
      .word_lo    (word_lo),
      .is_push    (op_is_push),
      .slot_clr   (slot_clr),
      .slot_start (slot_start),
      .slot_adv   (slot_adv)
   );

   pksyl_slot #(.NSYL(NSYL)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (slot_clr),
      .start  (slot_start),
      .adv    (slot_adv),
      .slot   (slot),
      .cur_idx(cur_idx),
      .last   (slot_last)
   );

   pksyl_unpack #(.WORD_W(WORD_W), .SYL_W(SYL_W), .NSYL(NSYL)) u_unpack (
      .word_lo(word_lo),
      .idx    (cur_idx),
      .syl    (op_syl),
      .imm    (op_imm)
   );

   assign imem_addr = pc;
endmodule

// File: rtl/pksyl_checker.sv
module pksyl_checker #(
   parameter  int AW     = 32,
   parameter  int WORD_W = 32,
   parameter  int SYL_W  = 6,
   parameter  int NSYL   = 5,
   localparam int SC_W   = $clog2(NSYL)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              freeze,
   input logic              imem_req,
   input logic              op_valid,
   input logic              op_ready,
   input logic              op_is_push,
   input logic [SYL_W-1:0]  op_syl,
   input logic [WORD_W-1:0] op_imm,
   input logic              jump_valid,
   input logic [AW-1:0]     jump_target,
   input logic              fault,
   input logic [AW-1:0]     pc,
   input logic [SC_W-1:0]   slot
);
   a_r5_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(slot) < NSYL);

   a_r2_push_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_is_push |-> slot == '0);

   a_r7_freeze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> !imem_req && !op_valid);

   a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(pc) && $stable(slot));

   a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready && !jump_valid |=>
         $stable(pc) && $stable(slot) && $stable(op_syl) && $stable(op_imm) && $stable(op_is_push));

   a_r4_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

   a_r4_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !imem_req && !op_valid);

   a_r4_fault_alone: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault, op_valid, imem_req}));

   a_r8_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
      jump_valid && !freeze && (imem_req || op_valid) |=>
         pc == $past(jump_target) && slot == '0);
endmodule

bind pksyl_sequencer pksyl_checker #(
   .AW(AW), .WORD_W(WORD_W), .SYL_W(SYL_W), .NSYL(NSYL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .freeze     (freeze),
   .imem_req   (imem_req),
   .op_valid   (op_valid),
   .op_ready   (op_ready),
   .op_is_push (op_is_push),
   .op_syl     (op_syl),
   .op_imm     (op_imm),
   .jump_valid (jump_valid),
   .jump_target(jump_target),
   .fault      (fault),
   .pc         (pc),
   .slot       (slot)
);

// File: tb/sim_pksyl_sequencer.sv
`timescale 1ns/1ps
module sim_pksyl_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b0;
   logic        imem_req;
   logic [31:0] imem_addr;
   logic [31:0] imem_rdata = '0;
   logic        op_valid;
   logic        op_ready = 1'b0;
   logic        op_is_push;
   logic [5:0]  op_syl;
   logic [31:0] op_imm;
   logic        jump_valid = 1'b0;
   logic [31:0] jump_target = '0;
   logic        fault;
   logic [31:0] pc;
   logic [2:0]  slot;

   always #2.5 clk = ~clk;

   pksyl_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .freeze(freeze),
      .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .op_valid(op_valid), .op_ready(op_ready), .op_is_push(op_is_push),
      .op_syl(op_syl), .op_imm(op_imm),
      .jump_valid(jump_valid), .jump_target(jump_target),
      .fault(fault), .pc(pc), .slot(slot)
   );

   // instruction memory: 256 words, synchronous read
   logic [31:0] mem [256];
   always @(posedge clk) imem_rdata <= mem[imem_addr[9:2]];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // behavioural reference: phase 0 fetch, 1 wait, 2 offer, 3 stopped
   int          m_phase;
   logic [31:0] m_pc, m_wa;
   logic [31:0] m_q[$];
   bit          m_push, m_fault;
   // history for stall / freeze / jump checks
   bit          p_stall, p_frz, p_jump;
   logic [31:0] p_pc, p_tgt, p_imm;
   logic [5:0]  p_syl;
   logic [2:0]  p_slot;
   int          jump_pct, rdy_pct, frz_pct, t200_pct;

   function automatic logic [2:0] exp_slot();
      if (m_phase == 2 && !m_push) return 3'((6 - m_q.size()) % 5);
      return 3'd0;
   endfunction

   task automatic compare();
      bit ev, er;
      er = (m_phase == 0) && !freeze;
      ev = (m_phase == 2) && !freeze;
      chk(imem_req == er, "R9 imem_req", 32'(imem_req), 32'(er));
      if (er) chk(imem_addr == m_pc, "R9 imem_addr", imem_addr, m_pc);
      chk(op_valid == ev, "R7 op_valid", 32'(op_valid), 32'(ev));
      if (ev) begin
         chk(op_is_push == m_push, "R2 op_is_push", 32'(op_is_push), 32'(m_push));
         if (m_push) begin
            chk(op_imm == m_q[0], "R2 op_imm", op_imm, m_q[0]);
            if (m_wa == 32'h0) chk(op_imm == 32'h80808080, "R2 example immediate", op_imm, 32'h80808080);
         end else begin
            chk(op_syl == m_q[0][5:0], "R3 op_syl order", 32'(op_syl), m_q[0]);
            if (m_wa == 32'h200 && m_q.size() == 3)
               chk(pc == 32'h204 && slot == 3'd3, "R5 third syllable at 0x200", {pc[28:0], slot}, {29'h204, 3'd3});
         end
      end
      chk(pc == m_pc, "R5 pc", pc, m_pc);
      chk(slot == exp_slot(), "R5 slot", 32'(slot), 32'(exp_slot()));
      chk(fault == m_fault, "R4 fault", 32'(fault), 32'(m_fault));
      if (m_phase == 3) chk(!imem_req && !op_valid, "R4 stopped quiet", {imem_req, op_valid}, 32'h0);
      if (p_stall) chk(op_syl == p_syl && op_imm == p_imm && pc == p_pc && slot == p_slot,
                       "R6 stall hold", {op_syl, slot, op_imm[22:0]}, {p_syl, p_slot, p_imm[22:0]});
      if (p_frz) chk(pc == p_pc && slot == p_slot, "R7 freeze hold", pc, p_pc);
      if (p_jump) chk(pc == p_tgt && slot == 3'd0, "R8 jump", pc, p_tgt);
      p_pc = pc; p_slot = slot; p_syl = op_syl; p_imm = op_imm;
   endtask

   task automatic step();
      logic [31:0] w;
      bit nf;
      nf = 1'b0;
      p_stall = (m_phase == 2) && !freeze && !op_ready && !jump_valid;
      p_frz   = freeze;
      p_jump  = jump_valid && !freeze && (m_phase != 3);
      p_tgt   = jump_target;
      if (m_phase == 3) begin
         // stopped until reset
      end else if (freeze) begin
         if (m_phase == 1) m_phase = 0;
      end else if (jump_valid) begin
         m_pc = jump_target;
         m_q.delete();
         m_phase = 0;
      end else if (m_phase == 0) begin
         m_phase = 1;
      end else if (m_phase == 1) begin
         w = mem[m_pc[9:2]];
         if (w[31]) begin
            m_q = '{{w[30:0], 1'b0}};
            m_push = 1; m_wa = m_pc; m_pc = m_pc + 4; m_phase = 2;
         end else if (w[30]) begin
            nf = 1'b1; m_phase = 3;
         end else begin
            m_q = '{32'(w[29:24]), 32'(w[23:18]), 32'(w[17:12]), 32'(w[11:6]), 32'(w[5:0])};
            m_push = 0; m_wa = m_pc; m_pc = m_pc + 4; m_phase = 2;
         end
      end else if (m_phase == 2 && op_ready) begin
         void'(m_q.pop_front());
         if (m_q.size() == 0) m_phase = 0;
      end
      m_fault = nf;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; freeze = 1'b0; jump_valid = 1'b0; op_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_phase = 0; m_pc = '0; m_wa = '1; m_q.delete(); m_push = 0; m_fault = 0;
      p_stall = 0; p_frz = 0; p_jump = 0;
      chk(pc == 32'h0 && slot == 3'd0, "R1 reset pc/slot", pc, 32'h0);
      chk(!op_valid && !fault, "R1 reset valid/fault", {op_valid, fault}, 32'h0);
      chk(imem_req && imem_addr == 32'h0, "R1 first request", imem_addr, 32'h0);
      compare();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         op_ready   = ($urandom_range(99) < rdy_pct);
         freeze     = ($urandom_range(99) < frz_pct);
         jump_valid = ($urandom_range(99) < jump_pct);
         jump_target = ($urandom_range(99) < t200_pct) ? 32'h200 : 32'($urandom_range(247)) * 4;
         step();
         @(negedge clk);
         compare();
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         logic [31:0] h;
         h = (32'(i) * 32'h9E3779B1) ^ (32'(i) << 7);
         if (i % 6 == 5) mem[i] = {1'b1, h[30:0]};
         else            mem[i] = {2'b00, h[29:0]};
      end
      mem[0]   = 32'hC0404040;
      mem[250] = 32'h4ABCDEF0;
      mem[251] = 32'h00000000;

      do_reset();
      rdy_pct = 100; frz_pct = 0; jump_pct = 0; t200_pct = 0;
      run(300);
      rdy_pct = 70; frz_pct = 10; jump_pct = 5; t200_pct = 20;
      run(3000);
      do_reset();
      rdy_pct = 100; frz_pct = 0; jump_pct = 0;
      run(2500);
      rdy_pct = 50; frz_pct = 20; jump_pct = 20;
      run(200);
      do_reset();
      rdy_pct = 40; frz_pct = 5; jump_pct = 3; t200_pct = 10;
      run(4000);
      do_reset();
      rdy_pct = 60; frz_pct = 0; jump_pct = 10; t200_pct = 50;
      run(2000);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run did not end, actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule